// File: doc/BRIEF.md
# Sub-Nyquist IF Down-converter with Gate Tagging

This block turns a stream of real 16-bit ADC samples into complex baseband I/Q gates. The samples are taken at 40 MHz from a 50 MHz intermediate frequency, so the wanted signal folds down to 10 MHz, which is a quarter of the sample rate. A quarter-rate mixer built from sign changes and zeroing moves that alias to DC without multipliers. A symmetric FIR low-pass filter follows the mixer. Its output is decimated by a factor set at a port.

A transmit trigger marks the start of each pulse. On the trigger the block restarts the mixer phase, empties the filter, and clears the decimation and range-gate counters. It also captures the time word, the antenna azimuth and elevation, and the transmit polarization state. Every gate of that pulse then leaves on a valid/ready stream carrying the I/Q pair, its gate index and those captured tags. No gates are produced until the first trigger after reset.

Top module: `ifdc_tagger`

## Requirements
- R1: After reset `out_valid` is 0. It stays 0, whatever the ADC input does, until the first `trig` pulse has been seen.
- R2: Accepted samples are mixed with a repeating four-step phase that starts at step 0 on each trigger. For steps 0,1,2,3 the I term is +x, 0, -x, 0 and the Q term is 0, -x, 0, +x. A sample is accepted when `adc_valid`=1 and `trig`=0.
- R3: Each channel is filtered by an 8-tap FIR with weights 1,2,3,4,4,3,2,1. Tap 0 holds the newest mixed sample. The sum is shifted arithmetically right by 3 (floor) to form the gate value.
- R4: One gate is produced for every N accepted samples, where N is the `decim` port value and 0 is treated as 1. The gate appears on the output one cycle after the clock edge that accepts the N-th sample.
- R5: All arithmetic saturates to the range -32768 to 32767. This covers both the negation of -32768 in the mixer, which gives 32767, and the filter output.
- R6: `out_gate` is 0 for the first gate after a trigger. It increases by 1 for each gate produced, including gates that are dropped.
- R7: `out_time`, `out_az`, `out_el` and `out_pol` equal the `time_in`, `az_in`, `el_in` and `pol_in` values sampled in the trigger cycle. They hold those values for every gate of the pulse, even when the inputs change.
- R8: While `out_valid`=1 and `out_ready`=0 the output word is held unchanged. A gate that completes during that time is dropped. `out_valid` falls after a transfer when no new gate completes.
- R9: A trigger zeroes the filter history, so the first gates of a pulse see zeros in the older taps. A sample offered in the trigger cycle is discarded. Cycles with `adc_valid`=0 advance neither the mixer phase nor the decimation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_valid | input | 1 | ADC sample present |
| adc_data | input | 16 | Signed ADC sample |
| trig | input | 1 | Transmit trigger, one cycle per pulse |
| time_in | input | 32 | Free-running time word |
| az_in | input | 16 | Antenna azimuth word |
| el_in | input | 16 | Antenna elevation word |
| pol_in | input | 2 | Transmit polarization state |
| decim | input | 4 | Decimation factor (0 acts as 1) |
| out_ready | input | 1 | Downstream can take a gate |
| out_valid | output | 1 | Gate word valid |
| out_i | output | 16 | Filtered in-phase value |
| out_q | output | 16 | Filtered quadrature value |
| out_gate | output | 12 | Range-gate index within the pulse |
| out_time | output | 32 | Time tag captured at the trigger |
| out_az | output | 16 | Azimuth captured at the trigger |
| out_el | output | 16 | Elevation captured at the trigger |
| out_pol | output | 2 | Polarization captured at the trigger |

## Verification
The bench drives a full-scale pattern whose mixed I term sits at the positive limit. A design that wraps instead of saturating, or that negates -32768 to itself, then flips the sign of the gate. Triggers are placed on a cycle that also carries a sample, after gaps in `adc_valid`, and partway through a decimation count. A design that keeps stale filter history, lets the mixer phase drift, or miscounts the decimation then produces wrong gate values or a wrong gate spacing. Random back-pressure checks that held words do not change, that a gate is dropped rather than overwriting the held word, and that the gate index still advances. Changing the tag inputs in mid-pulse exposes tags that are not latched.

// File: rtl/ifdc_tagger.sv
module ifdc_tagger #(
  parameter int DW    = 16,
  parameter int TAPS  = 8,
  parameter int SHIFT = 3,
  parameter int GW    = 12,
  parameter int TW    = 32,
  parameter int AW    = 16,
  parameter int PW    = 2,
  parameter int DECW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adc_valid,
  input  logic signed [DW-1:0] adc_data,
  input  logic                 trig,
  input  logic [TW-1:0]        time_in,
  input  logic [AW-1:0]        az_in,
  input  logic [AW-1:0]        el_in,
  input  logic [PW-1:0]        pol_in,
  input  logic [DECW-1:0]      decim,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic [GW-1:0]        out_gate,
  output logic [TW-1:0]        out_time,
  output logic [AW-1:0]        out_az,
  output logic [AW-1:0]        out_el,
  output logic [PW-1:0]        out_pol
);

  localparam int ACCW = DW + 2*$clog2(TAPS) + 2;
  localparam int HALF = TAPS / 2;
  localparam int MAXI = 2**(DW-1) - 1;
  localparam int MINI = -(2**(DW-1));

  function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
    if (v == DW'(MINI)) return DW'(MAXI);
    return -v;
  endfunction

  function automatic logic signed [ACCW-1:0] coef(input int k);
    int m;
    m = (k < TAPS-1-k) ? k : TAPS-1-k;
    return ACCW'(m + 1);
  endfunction

  function automatic logic signed [DW-1:0] clip(input logic signed [ACCW-1:0] v);
    if (v > $signed(ACCW'(MAXI))) return DW'(MAXI);
    if (v < $signed(ACCW'(MINI))) return DW'(MINI);
    return v[DW-1:0];
  endfunction

  logic                 armed;
  logic [1:0]           phase;
  logic [DECW-1:0]      dcnt;
  logic [GW-1:0]        gate_cnt;
  logic [TW-1:0]        lat_time;
  logic [AW-1:0]        lat_az, lat_el;
  logic [PW-1:0]        lat_pol;
  logic signed [DW-1:0] dli [TAPS];
  logic signed [DW-1:0] dlq [TAPS];
  logic signed [DW-1:0] tap_i [TAPS];
  logic signed [DW-1:0] tap_q [TAPS];
  logic signed [DW-1:0] mix_i, mix_q, y_i, y_q;
  logic signed [ACCW-1:0] acc_i, acc_q;
  logic [DECW-1:0]      dec_eff;
  logic                 take, emit;

  assign take    = armed && adc_valid && !trig;
  assign dec_eff = (decim == '0) ? DECW'(1) : decim;
  assign emit    = take && (({1'b0, dcnt} + 1'b1) >= {1'b0, dec_eff});

  always_comb begin
    mix_i = '0;
    mix_q = '0;
    case (phase)
      2'd0: mix_i = adc_data;
      2'd1: mix_q = neg_sat(adc_data);
      2'd2: mix_i = neg_sat(adc_data);
      default: mix_q = adc_data;
    endcase
  end

  assign tap_i[0] = mix_i;
  assign tap_q[0] = mix_q;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign tap_i[k] = dli[k-1];
    assign tap_q[k] = dlq[k-1];
  end

  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < HALF; k++) begin
      acc_i += coef(k) * (ACCW'(tap_i[k]) + ACCW'(tap_i[TAPS-1-k]));
      acc_q += coef(k) * (ACCW'(tap_q[k]) + ACCW'(tap_q[TAPS-1-k]));
    end
  end

  assign y_i = clip(acc_i >>> SHIFT);
  assign y_q = clip(acc_q >>> SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      phase    <= '0;
      dcnt     <= '0;
      gate_cnt <= '0;
      lat_time <= '0;
      lat_az   <= '0;
      lat_el   <= '0;
      lat_pol  <= '0;
      for (int k = 0; k < TAPS; k++) begin
        dli[k] <= '0;
        dlq[k] <= '0;
      end
    end else if (trig) begin
      armed    <= 1'b1;
      phase    <= '0;
      dcnt     <= '0;
      gate_cnt <= '0;
      lat_time <= time_in;
      lat_az   <= az_in;
      lat_el   <= el_in;
      lat_pol  <= pol_in;
      for (int k = 0; k < TAPS; k++) begin
        dli[k] <= '0;
        dlq[k] <= '0;
      end
    end else if (take) begin
      phase <= phase + 2'd1;
      dcnt  <= emit ? '0 : dcnt + 1'b1;
      if (emit) gate_cnt <= gate_cnt + 1'b1;
      for (int k = 0; k < TAPS; k++) begin
        dli[k] <= tap_i[k];
        dlq[k] <= tap_q[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      out_gate  <= '0;
      out_time  <= '0;
      out_az    <= '0;
      out_el    <= '0;
      out_pol   <= '0;
    end else if (emit && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_i     <= y_i;
      out_q     <= y_q;
      out_gate  <= gate_cnt;
      out_time  <= lat_time;
      out_az    <= lat_az;
      out_el    <= lat_el;
      out_pol   <= lat_pol;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_IDLE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !out_valid);  // R1
  AST_GATE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!emit && !trig) |=> $stable(gate_cnt));  // R6
  AST_TAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !trig) |=> ($stable(lat_az) && $stable(lat_el) && $stable(lat_pol) && $stable(lat_time)));  // R7
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_gate)));  // R8
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !emit) |=> !out_valid);  // R8

endmodule

// File: tb/ifdc_tagger_tb.sv
module ifdc_tagger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_valid = 1'b0;
  logic signed [15:0] adc_data = '0;
  logic trig = 1'b0;
  logic [31:0] time_in = '0;
  logic [15:0] az_in = '0, el_in = '0;
  logic [1:0] pol_in = '0;
  logic [3:0] decim = 4'd1;
  logic out_ready = 1'b1;
  logic out_valid;
  logic signed [15:0] out_i, out_q;
  logic [11:0] out_gate;
  logic [31:0] out_time;
  logic [15:0] out_az, out_el;
  logic [1:0] out_pol;

  ifdc_tagger dut_i (
    .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_data(adc_data), .trig(trig),
    .time_in(time_in), .az_in(az_in), .el_in(el_in), .pol_in(pol_in), .decim(decim),
    .out_ready(out_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .out_gate(out_gate), .out_time(out_time), .out_az(out_az), .out_el(out_el), .out_pol(out_pol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  bit rand_ready = 0;
  bit saw_pos_sat = 0;
  int last_gate = -1;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // behavioural reference model
  int c[8] = '{1, 2, 3, 4, 4, 3, 2, 1};
  int hi[8], hq[8];
  bit m_armed = 0, e_valid = 0;
  int m_phase, m_dcnt, m_gate;
  int l_time, l_az, l_el, l_pol;
  int e_i, e_q, e_gate, e_time, e_az, e_el, e_pol;

  always @(posedge clk) begin
    int x, mi, mq, dec, yi, yq, g;
    bit emit;
    if (!rst_n) begin
      m_armed = 0; e_valid = 0;
    end else begin
      emit = 0;
      dec = (decim == 0) ? 1 : int'(decim);
      if (trig) begin
        m_armed = 1; m_phase = 0; m_dcnt = 0; m_gate = 0;
        for (int k = 0; k < 8; k++) begin hi[k] = 0; hq[k] = 0; end
        l_time = int'(time_in); l_az = int'(az_in); l_el = int'(el_in); l_pol = int'(pol_in);
      end else if (m_armed && adc_valid) begin
        x = int'(adc_data);
        mi = 0; mq = 0;
        if (m_phase == 0) mi = x;
        if (m_phase == 1) mq = sat(-x);
        if (m_phase == 2) mi = sat(-x);
        if (m_phase == 3) mq = x;
        for (int k = 7; k > 0; k--) begin hi[k] = hi[k-1]; hq[k] = hq[k-1]; end
        hi[0] = mi; hq[0] = mq;
        m_phase = (m_phase + 1) % 4;
        if (m_dcnt + 1 >= dec) begin
          emit = 1; m_dcnt = 0; g = m_gate; m_gate = m_gate + 1;
        end else m_dcnt = m_dcnt + 1;
        yi = 0; yq = 0;
        for (int k = 0; k < 8; k++) begin yi += c[k] * hi[k]; yq += c[k] * hq[k]; end
        yi = sat(yi >>> 3); yq = sat(yq >>> 3);
      end
      if (emit && (!e_valid || out_ready)) begin
        e_valid = 1; e_i = yi; e_q = yq; e_gate = g & 12'hFFF;
        e_time = l_time; e_az = l_az; e_el = l_el; e_pol = l_pol;
      end else if (out_ready) e_valid = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(out_valid == e_valid, "R4 R8 R1", "out_valid", out_valid, e_valid);
      if (e_valid && out_valid) begin
        chk(int'(out_i) == e_i, "R2 R3 R5 R9", "out_i", out_i, e_i);
        chk(int'(out_q) == e_q, "R2 R3 R5 R9", "out_q", out_q, e_q);
        chk(int'(out_gate) == e_gate, "R6", "out_gate", out_gate, e_gate);
        chk(int'(out_time) == e_time && int'(out_az) == e_az && int'(out_el) == e_el
            && int'(out_pol) == e_pol, "R7", "tags az", out_az, e_az);
        if (out_i == 16'sd32767) saw_pos_sat = 1;
        last_gate = int'(out_gate);
      end
      if (rand_ready) out_ready = $urandom_range(0, 1) == 1;
    end
  end

  task automatic tick; @(negedge clk); endtask

  task automatic sample(int x);
    adc_valid = 1; adc_data = 16'(x); tick(); adc_valid = 0;
  endtask

  task automatic pulse(int t, int az, int el, int pol);
    time_in = 32'(t); az_in = 16'(az); el_in = 16'(el); pol_in = 2'(pol);
    trig = 1; tick(); trig = 0;
  endtask

  initial begin
    repeat (3) tick();
    chk(out_valid == 0, "R1", "valid in reset", out_valid, 0);
    rst_n = 1;
    // R1: samples before any trigger give nothing
    for (int n = 0; n < 20; n++) sample(1000 + n);
    chk(out_valid == 0, "R1", "valid before trigger", out_valid, 0);

    // pulse A: decim 1, quarter-rate tone
    decim = 4'd1;
    pulse(100, 1111, 222, 1);
    for (int n = 0; n < 24; n++) sample((n % 4 == 0) ? 8000 : (n % 4 == 2) ? -8000 : 3000);
    tick(); tick();
    chk(last_gate == 23, "R6", "last gate pulse A", last_gate, 23);

    // pulse B: decim 3, gaps, tags changed mid-pulse (R7, R9)
    decim = 4'd3;
    pulse(200, 3333, 444, 2);
    for (int n = 0; n < 30; n++) begin
      if (n % 5 == 2) tick();
      if (n == 10) begin az_in = 16'd9; el_in = 16'd9; pol_in = 2'd0; time_in = 32'd9; end
      sample(int'($urandom_range(0, 20000)) - 10000);
    end
    tick(); tick();
    chk(last_gate == 9, "R4", "gates for 30 samples at decim 3", last_gate, 9);

    // pulse C: saturation, decim 2; trigger cycle carries a sample (R9)
    decim = 4'd2;
    time_in = 32'd300; az_in = 16'd5; el_in = 16'd6; pol_in = 2'd3;
    adc_valid = 1; adc_data = 16'sh7fff; trig = 1; tick(); trig = 0; adc_valid = 0;
    for (int n = 0; n < 32; n++) sample((n % 4 == 0) ? 32767 : (n % 4 == 2) ? -32768 : -32768);
    tick(); tick();
    chk(saw_pos_sat, "R5", "positive saturation reached", saw_pos_sat, 1);

    // pulse D: decim 0 acts as 1, random back-pressure (R8)
    decim = 4'd0;
    pulse(400, 77, 88, 0);
    rand_ready = 1;
    for (int n = 0; n < 200; n++) sample(int'($urandom_range(0, 65535)) - 32768);
    rand_ready = 0; out_ready = 1;
    tick(); tick();
    chk(last_gate <= 199, "R8", "gate index bound under drops", last_gate, 199);

    // pulse E: mid-count retrigger, decim 4
    decim = 4'd4;
    pulse(500, 1, 2, 1);
    for (int n = 0; n < 6; n++) sample(12345);
    pulse(600, 3, 4, 2);
    for (int n = 0; n < 16; n++) sample((n % 2 == 0) ? 20000 : -15000);
    tick(); tick();
    chk(last_gate == 3, "R6", "gate restart after retrigger", last_gate, 3);
    chk(out_valid == 0, "R8", "valid cleared when idle", out_valid, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule